// File: doc/BRIEF.md
# Variable-Length Instruction Byte Aligner

This front-end stage sits between instruction fetch and the decoders. Fetch hands it 16-byte blocks. Each byte arrives with a pre-decode end mark, and with a fault flag raised when that byte could not be fetched. The bytes enter a 32-byte queue. The oldest queued byte always lies at the current fetch program counter.

Each cycle the stage cuts up to three complete instructions off the front of the queue. It finds their edges from the end marks alone. Every extracted instruction goes out on its own slot with its address, length and bytes. The program counter then moves forward by the total length consumed. Downstream can freeze the stage with a stall. A redirect discards everything and restarts at a new address.

A fault on any byte of the oldest instruction is reported at that instruction's first byte. This covers a missing second page under an instruction that spans two pages. The partial bytes are dropped, and the stage then waits for a redirect.

Top module: `vl_aligner`

## Requirements
- R1: After reset the queue is empty, no slot is valid, `fault_valid` is low, `in_ready` is high and `head_pc` equals the `RESET_PC` parameter.
- R2: A byte whose `in_end` bit is 1 is the last byte of an instruction, and the next byte in the stream starts a new one. The length is the count of bytes from the start byte through the end byte, from 1 to 15.
- R3: The queue holds 32 bytes. `in_ready` is high exactly when at most 16 bytes are queued and none of stall, redirect, a fault report or the halted state is present. An accepted block is appended behind the bytes already queued, with byte 0 (`in_bytes[7:0]`) first.
- R4: Up to three instructions are presented per cycle in program order, starting at slot 0 with no gaps. Slot k uses `out_pc[32k+31:32k]`, `out_len[4k+3:4k]` and `out_bytes[120k+119:120k]`. Instruction byte j sits at bits 8j within the slot's field, and bytes past the length are zero.
- R5: An instruction whose end byte is not yet queued is not presented. No later slot is valid in that cycle.
- R6: In a cycle without stall, `head_pc` advances by the sum of the lengths of the valid slots. Every valid slot is consumed in that cycle.
- R7: While `stall` is high, the queue, `head_pc` and every output hold their values, and no block is accepted. No instruction is lost or repeated across the stall.
- R8: `redirect` blanks all slots and `fault_valid` in its own cycle and empties the queue. From the next cycle, `head_pc` equals `redirect_pc`.
- R9: When the oldest instruction, or the oldest partial instruction, contains a byte with its fault flag set, `fault_valid` pulses with `fault_pc` equal to that instruction's first byte address. No slot is valid in that cycle. The queue is then emptied and input stays refused until a redirect.
- R10: Complete instructions that precede a faulting one in the stream are presented normally before the fault is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetch block present |
| in_ready | output | 1 | Block accepted this cycle if `in_valid` |
| in_bytes | input | 128 | Fetched bytes, byte 0 in bits 7:0 |
| in_end | input | 16 | Per-byte end-of-instruction mark |
| in_fault | input | 16 | Per-byte fetch fault flag |
| redirect | input | 1 | Flush and restart |
| redirect_pc | input | 32 | Restart address |
| stall | input | 1 | Downstream back-pressure |
| out_valid | output | 3 | Per-slot valid |
| out_pc | output | 96 | Per-slot start address |
| out_len | output | 12 | Per-slot length in bytes |
| out_bytes | output | 360 | Per-slot instruction bytes, left-aligned |
| fault_valid | output | 1 | Fault report pulse |
| fault_pc | output | 32 | First byte address of the faulting instruction |
| head_pc | output | 32 | Address of the oldest queued byte |

## Verification
The hardest case to reach is a fault flag on the trailing bytes of an instruction that crosses a block boundary, while complete instructions ahead of it in the same queue window are still waiting to leave. The stimulus marks every byte from a random offset to the end of some blocks as faulted. It also uses sparse fetch and long instructions, so that spanning instructions are common. The random stall then lets the faulted block land behind queued work. The bench's own queue model decides, cycle by cycle, which instructions come out first and when the report appears.

// File: rtl/vl_aligner.sv
module vl_aligner #(
  parameter int FETCH_W  = 16,
  parameter int QDEPTH   = 32,
  parameter int SLOTS    = 3,
  parameter int MAXLEN   = 15,
  parameter int AW       = 32,
  parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [FETCH_W*8-1:0]        in_bytes,
  input  logic [FETCH_W-1:0]          in_end,
  input  logic [FETCH_W-1:0]          in_fault,
  input  logic                        redirect,
  input  logic [AW-1:0]               redirect_pc,
  input  logic                        stall,
  output logic [SLOTS-1:0]            out_valid,
  output logic [SLOTS*AW-1:0]         out_pc,
  output logic [SLOTS*$clog2(MAXLEN+1)-1:0] out_len,
  output logic [SLOTS*MAXLEN*8-1:0]   out_bytes,
  output logic                        fault_valid,
  output logic [AW-1:0]               fault_pc,
  output logic [AW-1:0]               head_pc
);
  localparam int CW  = $clog2(QDEPTH+1);
  localparam int IW  = $clog2(QDEPTH);
  localparam int FIW = $clog2(FETCH_W);
  localparam int LW  = $clog2(MAXLEN+1);

  logic [7:0]        q_b [QDEPTH];
  logic [QDEPTH-1:0] q_e, q_f;
  logic [CW-1:0]     cnt_q;
  logic [AW-1:0]     pc_q;
  logic              halted_q;

  logic [7:0]        n_b [QDEPTH];
  logic [QDEPTH-1:0] n_e, n_f;
  logic [CW-1:0]     n_cnt;
  logic [CW-1:0]     consumed;
  logic              flt0, take;

  always_comb begin
    int s;
    logic go, done, flt;
    logic [LW-1:0] len;
    out_valid = '0; out_pc = '0; out_len = '0; out_bytes = '0;
    flt0 = 1'b0; go = !halted_q; s = 0;
    for (int k = 0; k < SLOTS; k++) begin
      done = 1'b0; flt = 1'b0; len = '0;
      for (int j = 0; j < MAXLEN; j++) begin
        if (go && !done && (s + j < int'(cnt_q))) begin
          if (q_f[IW'(s+j)]) flt = 1'b1;
          if (q_e[IW'(s+j)]) begin done = 1'b1; len = LW'(j+1); end
        end
      end
      if (go && flt && k == 0) flt0 = 1'b1;
      if (go && done && !flt) begin
        out_valid[k] = 1'b1;
        out_pc[k*AW +: AW] = pc_q + AW'(s);
        out_len[k*LW +: LW] = len;
        for (int j = 0; j < MAXLEN; j++)
          if (j < int'(len)) out_bytes[(k*MAXLEN+j)*8 +: 8] = q_b[IW'(s+j)];
        s = s + int'(len);
      end else begin
        go = 1'b0;
      end
    end
    consumed = CW'(s);
    if (redirect) out_valid = '0;
  end

  assign fault_valid = flt0 && !redirect;
  assign fault_pc    = pc_q;
  assign head_pc     = pc_q;
  assign in_ready    = (cnt_q <= CW'(QDEPTH-FETCH_W)) && !stall && !halted_q && !redirect && !flt0;
  assign take        = in_valid && in_ready;

  always_comb begin
    int pop, remain, off;
    pop    = stall ? 0 : int'(consumed);
    remain = int'(cnt_q) - pop;
    for (int i = 0; i < QDEPTH; i++) begin
      n_b[i] = '0; n_e[i] = 1'b0; n_f[i] = 1'b0;
      off = i - remain;
      if (i < remain) begin
        n_b[i] = q_b[IW'(i+pop)];
        n_e[i] = q_e[IW'(i+pop)];
        n_f[i] = q_f[IW'(i+pop)];
      end else if (take && off < FETCH_W) begin
        n_b[i] = in_bytes[{FIW'(off), 3'b000} +: 8];
        n_e[i] = in_end[FIW'(off)];
        n_f[i] = in_fault[FIW'(off)];
      end
    end
    n_cnt = CW'(remain + (take ? FETCH_W : 0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0; pc_q <= AW'(RESET_PC); halted_q <= 1'b0;
      q_e <= '0; q_f <= '0;
      for (int i = 0; i < QDEPTH; i++) q_b[i] <= '0;
    end else if (redirect) begin
      cnt_q <= '0; pc_q <= redirect_pc; halted_q <= 1'b0;
    end else if (flt0) begin
      cnt_q <= '0; halted_q <= 1'b1;
    end else begin
      for (int i = 0; i < QDEPTH; i++) q_b[i] <= n_b[i];
      q_e <= n_e; q_f <= n_f; cnt_q <= n_cnt;
      if (!stall) pc_q <= pc_q + AW'(consumed);
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(QDEPTH));
  a_r3_ready_room: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (cnt_q <= CW'(QDEPTH-FETCH_W)));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !redirect && !fault_valid) |=> ($stable(cnt_q) && $stable(pc_q)));
  a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (cnt_q == '0 && head_pc == $past(redirect_pc)));
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (out_valid == '0));
  a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> (cnt_q == '0 && !in_ready));

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot_chk
    a_r2_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[k] |-> (out_len[k*LW +: LW] != '0));
    if (k > 0) begin : g_link
      a_r4_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[k] |-> out_valid[k-1]);
      a_r4_chain: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid[k] |-> (out_pc[k*AW +: AW] ==
          out_pc[(k-1)*AW +: AW] + AW'(out_len[(k-1)*LW +: LW])));
    end
  end
endmodule

// File: tb/vl_aligner_tb.sv
module vl_aligner_tb;
  localparam logic [31:0] RST_PC = 32'h0000_1000;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, redirect = 0, stall = 0, fault_valid;
  logic [127:0] in_bytes = '0;
  logic [15:0]  in_end = '0, in_fault = '0;
  logic [31:0]  redirect_pc = '0, fault_pc, head_pc;
  logic [2:0]   out_valid;
  logic [95:0]  out_pc;
  logic [11:0]  out_len;
  logic [359:0] out_bytes;

  vl_aligner #(.RESET_PC(RST_PC)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bytes(in_bytes), .in_end(in_end), .in_fault(in_fault),
    .redirect(redirect), .redirect_pc(redirect_pc), .stall(stall),
    .out_valid(out_valid), .out_pc(out_pc), .out_len(out_len), .out_bytes(out_bytes),
    .fault_valid(fault_valid), .fault_pc(fault_pc), .head_pc(head_pc));

  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0, cyc = 0;
  string cur_req = "R1";

  logic [7:0] mq_b[$]; logic mq_e[$], mq_f[$];
  logic [7:0] g_b[$];  logic g_e[$];
  logic [31:0] mpc; logic mhalt;
  logic [2:0] e_valid; logic [31:0] e_pc[3]; logic [3:0] e_len[3]; logic [119:0] e_bytes[3];
  logic e_flt, e_ready; int e_cons;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired: actual cycle %0d expected < 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  function automatic void gen_fill(int lo, int hi);
    while (g_b.size() < 16) begin
      int len = $urandom_range(hi, lo);
      for (int j = 0; j < len; j++) begin
        g_b.push_back(8'($urandom)); g_e.push_back(j == len-1);
      end
    end
  endfunction

  function automatic void model_eval();
    int s = 0; bit go = !mhalt;
    e_valid = '0; e_flt = 0;
    for (int k = 0; k < 3; k++) begin
      bit done = 0, flt = 0; int len = 0;
      e_pc[k] = '0; e_len[k] = '0; e_bytes[k] = '0;
      for (int j = 0; j < 15; j++)
        if (go && !done && s + j < mq_b.size()) begin
          if (mq_f[s+j]) flt = 1;
          if (mq_e[s+j]) begin done = 1; len = j + 1; end
        end
      if (go && flt && k == 0) e_flt = 1;
      if (go && done && !flt) begin
        e_valid[k] = 1; e_pc[k] = mpc + s; e_len[k] = 4'(len);
        for (int j = 0; j < len; j++) e_bytes[k][8*j +: 8] = mq_b[s+j];
        s += len;
      end else go = 0;
    end
    e_cons = s;
    if (redirect) begin e_valid = '0; e_flt = 0; end
    e_ready = (mq_b.size() <= 16) && !stall && !mhalt && !redirect && !e_flt;
  endfunction

  task automatic check_all();
    bit bad = 0;
    n_tests++;
    if (out_valid !== e_valid) begin bad = 1;
      $display("FAIL %s R4 out_valid: actual %b expected %b", cur_req, out_valid, e_valid); end
    for (int k = 0; k < 3; k++) if (e_valid[k]) begin
      if (out_pc[32*k +: 32] !== e_pc[k] || out_len[4*k +: 4] !== e_len[k] ||
          out_bytes[120*k +: 120] !== e_bytes[k]) begin bad = 1;
        $display("FAIL %s R4 slot%0d: actual pc %h len %0d bytes %h expected pc %h len %0d bytes %h",
          cur_req, k, out_pc[32*k +: 32], out_len[4*k +: 4], out_bytes[120*k +: 120],
          e_pc[k], e_len[k], e_bytes[k]); end
    end
    if (fault_valid !== e_flt || (e_flt && fault_pc !== mpc)) begin bad = 1;
      $display("FAIL %s R9 fault: actual %b @%h expected %b @%h", cur_req, fault_valid, fault_pc, e_flt, mpc); end
    if (in_ready !== e_ready) begin bad = 1;
      $display("FAIL %s R3 in_ready: actual %b expected %b", cur_req, in_ready, e_ready); end
    if (head_pc !== mpc) begin bad = 1;
      $display("FAIL %s R6 head_pc: actual %h expected %h", cur_req, head_pc, mpc); end
    if (bad) n_fail++;
  endtask

  function automatic void model_update();
    if (redirect) begin
      mq_b.delete(); mq_e.delete(); mq_f.delete(); g_b.delete(); g_e.delete();
      mpc = redirect_pc; mhalt = 0;
    end else if (e_flt) begin
      mq_b.delete(); mq_e.delete(); mq_f.delete(); mhalt = 1;
    end else begin
      if (!stall) begin
        repeat (e_cons) begin void'(mq_b.pop_front()); void'(mq_e.pop_front()); void'(mq_f.pop_front()); end
        mpc += e_cons;
      end
      if (in_valid && e_ready) for (int j = 0; j < 16; j++) begin
        mq_b.push_back(in_bytes[8*j +: 8]); mq_e.push_back(in_end[j]); mq_f.push_back(in_fault[j]);
        void'(g_b.pop_front()); void'(g_e.pop_front());
      end
    end
  endfunction

  task automatic run_phase(string tag, int n, int pv, int ps, int pr, int pf, int lo, int hi);
    cur_req = tag;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      gen_fill(lo, hi);
      in_valid = ($urandom_range(99, 0) < pv);
      for (int j = 0; j < 16; j++) begin in_bytes[8*j +: 8] = g_b[j]; in_end[j] = g_e[j]; end
      in_fault = '0;
      if ($urandom_range(99, 0) < pf) begin
        int off = $urandom_range(15, 0);
        for (int j = off; j < 16; j++) in_fault[j] = 1'b1;
      end
      stall = ($urandom_range(99, 0) < ps);
      redirect = mhalt || ($urandom_range(99, 0) < pr);
      redirect_pc = $urandom;
      #2;
      model_eval(); check_all(); model_update();
    end
  endtask

  initial begin
    mpc = RST_PC; mhalt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    n_tests++;
    if (out_valid !== 3'b000 || in_ready !== 1'b1 || head_pc !== RST_PC || fault_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: actual valid %b ready %b pc %h fault %b expected 000 1 %h 0",
        out_valid, in_ready, head_pc, fault_valid, RST_PC);
    end
    run_phase("R2", 400, 90, 0, 0, 0, 1, 4);
    run_phase("R5", 400, 25, 0, 0, 0, 10, 15);
    run_phase("R6", 400, 70, 10, 0, 0, 1, 15);
    run_phase("R7", 600, 60, 50, 0, 0, 1, 8);
    run_phase("R8", 400, 70, 20, 8, 0, 1, 15);
    run_phase("R9", 600, 40, 30, 1, 15, 6, 15);
    run_phase("R10", 600, 80, 40, 1, 10, 1, 6);
    run_phase("mix", 2000, 60, 25, 2, 4, 1, 15);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule